// File: doc/BRIEF.md
# Switch Soft-Reset Sequencer

This block performs a soft reset of a multi-port switch on its own, acting as the master on a simple register read/write bus. A single start pulse begins the sequence. First, each port's control register is fetched in turn and written back with its forwarding-state field cleared, which takes the port out of service. The block then idles for two milliseconds so that frames already queued for transmit can leave. It then writes the global reset command and polls the global status word once per millisecond until the reset-complete bits read back as set.

The sequence ends with a one-cycle `done` pulse on success, or a one-cycle `timeout` pulse if the poll budget runs out. After either pulse the block returns to idle. Only one register access is ever in flight. A request, together with its address, write flag and write data, is held until the bus acknowledges it. Read data is taken in the cycle the acknowledge is seen.

Register addresses are `{device[4:0], offset[4:0]}`. Port `i` is device `PORT_BASE + i`, and the global registers sit at device `GLOBAL_DEV`. Time is counted in clock cycles, with `TICKS_PER_MS` cycles per millisecond.

Top module: `sw_reset_seq`

## Requirements
- R1: After reset, and while idle with no start, `regReq`, `done` and `timeout` are low and no access is issued.
- R2: After start, ports 0 to NUM_PORTS-1 are visited in ascending order. Each port gets a read and then a write, both at offset 4 of device PORT_BASE+i. Each access is requested on the cycle after the previous acknowledge.
- R3: Each port write carries the value read from that port with bits [1:0] cleared and all other bits unchanged.
- R4: A request, with its address, write flag and write data, stays asserted and stable until `regAck`. At most one access is outstanding.
- R5: The reset write is requested on cycle 2*TICKS_PER_MS+1 counted from the cycle in which the last port write was acknowledged.
- R6: The reset command writes 0xC400 to offset 4 of device GLOBAL_DEV.
- R7: Status reads target offset 0 of device GLOBAL_DEV. The first read is requested on the cycle after the reset write is acknowledged. Each retry is requested TICKS_PER_MS+1 cycles after the previous failed read was acknowledged.
- R8: A status read whose data ANDed with 0xC800 equals 0xC800 ends the sequence with a `done` pulse on the cycle after its acknowledge.
- R9: If MAX_POLLS status reads all fail, `timeout` pulses after the last one and no further access is issued.
- R10: Exactly one of `done` and `timeout` pulses per sequence, for one cycle, with `regReq` low, after which the block is idle.
- R11: A start pulse while a sequence is running has no effect: the access count and the single completion pulse are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin the reset sequence |
| regReq | output | 1 | Register access request, held until acknowledged |
| regWe | output | 1 | 1 for a write, 0 for a read |
| regAddr | output | 10 | {device[4:0], offset[4:0]} |
| regWdata | output | 16 | Write data |
| regAck | input | 1 | Access complete; read data valid in this cycle |
| regRdata | input | 16 | Read data |
| done | output | 1 | One-cycle pulse: reset completion observed |
| timeout | output | 1 | One-cycle pulse: poll budget exhausted |

## Verification
The bench builds the block with eight ports, TICKS_PER_MS of 3 and MAX_POLLS of 4. The two-millisecond drain and the one-millisecond poll spacing therefore shrink to a few cycles, and their exact lengths can be measured against every acknowledge. The small poll budget puts both sides of the limit within reach: success on the very last allowed read, and timeout when every read fails. Bus latencies from zero to three wait cycles, partially set status masks and a stray start during the port sweep exercise handshake holding and start rejection.

// File: rtl/sw_reset_pkg.sv
package sw_reset_pkg;
  localparam int DEV_W  = 5;
  localparam int OFF_W  = 5;
  localparam int ADDR_W = DEV_W + OFF_W;
  localparam int DATA_W = 16;

  localparam logic [OFF_W-1:0]  OFF_PORT_CTRL = 5'd4;
  localparam logic [OFF_W-1:0]  OFF_GLB_CTRL  = 5'd4;
  localparam logic [OFF_W-1:0]  OFF_GLB_STAT  = 5'd0;
  localparam logic [DATA_W-1:0] RESET_CMD     = 16'hC400;
  localparam logic [DATA_W-1:0] DONE_MASK     = 16'hC800;
  localparam logic [DATA_W-1:0] FWD_STATE_MSK = 16'h0003;

  typedef enum logic [1:0] {
    ACC_PORT_RD, ACC_PORT_WR, ACC_GLB_WR, ACC_STAT_RD
  } accKind_t;

  typedef struct packed {
    logic     clrPort;
    logic     incPort;
    logic     capture;
    logic     loadDrain;
    logic     loadGap;
    logic     clrPoll;
    logic     incPoll;
    accKind_t accKind;
  } ctrlStrobe_t;

  typedef struct packed {
    logic lastPort;
    logic timerZero;
    logic lastPoll;
    logic statusOk;
  } dpStatus_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PORT_RD, S_PORT_WR, S_DRAIN, S_RST_WR, S_STAT_RD, S_GAP
  } seqState_t;
endpackage

// File: rtl/sw_reset_dp.sv
module sw_reset_dp
  import sw_reset_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int PORT_BASE    = 16,
  parameter int GLOBAL_DEV   = 27,
  parameter int TICKS_PER_MS = 100000,
  parameter int MAX_POLLS    = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] regRdata,
  output dpStatus_t         status,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata
);
  localparam int PORT_W      = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam int DRAIN_TICKS = 2 * TICKS_PER_MS;
  localparam int TMR_W       = $clog2(DRAIN_TICKS + 1);
  localparam int POLL_W      = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  logic [PORT_W-1:0] portIdx;
  logic [TMR_W-1:0]  tmr;
  logic [POLL_W-1:0] pollCnt;
  logic [DATA_W-1:0] heldCtrl;
  logic [DEV_W-1:0]  portDev;
  logic [DEV_W-1:0]  globalDev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portIdx  <= '0;
      tmr      <= '0;
      pollCnt  <= '0;
      heldCtrl <= '0;
    end else begin
      if (strobe.clrPort)      portIdx <= '0;
      else if (strobe.incPort) portIdx <= portIdx + 1'b1;

      if (strobe.loadDrain)    tmr <= TMR_W'(DRAIN_TICKS - 1);
      else if (strobe.loadGap) tmr <= TMR_W'(TICKS_PER_MS - 1);
      else if (tmr != '0)      tmr <= tmr - 1'b1;

      if (strobe.clrPoll)      pollCnt <= '0;
      else if (strobe.incPoll) pollCnt <= pollCnt + 1'b1;

      if (strobe.capture)      heldCtrl <= regRdata;
    end
  end

  assign portDev   = DEV_W'(PORT_BASE) + DEV_W'(portIdx);
  assign globalDev = DEV_W'(GLOBAL_DEV);

  always_comb begin
    regWe    = 1'b0;
    regWdata = '0;
    regAddr  = {portDev, OFF_PORT_CTRL};
    case (strobe.accKind)
      ACC_PORT_RD: regAddr = {portDev, OFF_PORT_CTRL};
      ACC_PORT_WR: begin
        regWe    = 1'b1;
        regAddr  = {portDev, OFF_PORT_CTRL};
        regWdata = heldCtrl & ~FWD_STATE_MSK;
      end
      ACC_GLB_WR: begin
        regWe    = 1'b1;
        regAddr  = {globalDev, OFF_GLB_CTRL};
        regWdata = RESET_CMD;
      end
      ACC_STAT_RD: regAddr = {globalDev, OFF_GLB_STAT};
      default: regAddr = {portDev, OFF_PORT_CTRL};
    endcase
  end

  assign status.lastPort  = (portIdx == PORT_W'(NUM_PORTS - 1));
  assign status.timerZero = (tmr == '0);
  assign status.lastPoll  = (pollCnt == POLL_W'(MAX_POLLS - 1));
  assign status.statusOk  = ((regRdata & DONE_MASK) == DONE_MASK);
endmodule

// File: rtl/sw_reset_ctrl.sv
module sw_reset_ctrl
  import sw_reset_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        regAck,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        regReq,
  output logic        done,
  output logic        timeout
);
  seqState_t state, nextState;
  logic doneSet, toSet;

  always_comb begin
    strobe    = '0;
    nextState = state;
    doneSet   = 1'b0;
    toSet     = 1'b0;
    case (state)
      S_IDLE: if (start) begin
        strobe.clrPort = 1'b1;
        nextState      = S_PORT_RD;
      end
      S_PORT_RD: begin
        strobe.accKind = ACC_PORT_RD;
        if (regAck) begin
          strobe.capture = 1'b1;
          nextState      = S_PORT_WR;
        end
      end
      S_PORT_WR: begin
        strobe.accKind = ACC_PORT_WR;
        if (regAck) begin
          if (status.lastPort) begin
            strobe.loadDrain = 1'b1;
            nextState        = S_DRAIN;
          end else begin
            strobe.incPort = 1'b1;
            nextState      = S_PORT_RD;
          end
        end
      end
      S_DRAIN: if (status.timerZero) nextState = S_RST_WR;
      S_RST_WR: begin
        strobe.accKind = ACC_GLB_WR;
        if (regAck) begin
          strobe.clrPoll = 1'b1;
          nextState      = S_STAT_RD;
        end
      end
      S_STAT_RD: begin
        strobe.accKind = ACC_STAT_RD;
        if (regAck) begin
          if (status.statusOk) begin
            doneSet   = 1'b1;
            nextState = S_IDLE;
          end else if (status.lastPoll) begin
            toSet     = 1'b1;
            nextState = S_IDLE;
          end else begin
            strobe.incPoll = 1'b1;
            strobe.loadGap = 1'b1;
            nextState      = S_GAP;
          end
        end
      end
      S_GAP: if (status.timerZero) nextState = S_STAT_RD;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      done    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      state   <= nextState;
      done    <= doneSet;
      timeout <= toSet;
    end
  end

  assign regReq = (state == S_PORT_RD) || (state == S_PORT_WR) ||
                  (state == S_RST_WR)  || (state == S_STAT_RD);
endmodule

// File: rtl/sw_reset_seq.sv
module sw_reset_seq
  import sw_reset_pkg::*;
#(
  parameter int NUM_PORTS    = 8,
  parameter int PORT_BASE    = 16,
  parameter int GLOBAL_DEV   = 27,
  parameter int TICKS_PER_MS = 100000,
  parameter int MAX_POLLS    = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              regReq,
  output logic              regWe,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck,
  input  logic [DATA_W-1:0] regRdata,
  output logic              done,
  output logic              timeout
);
  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;

  sw_reset_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .regAck(regAck),
    .status(dpStat), .strobe(strobe), .regReq(regReq),
    .done(done), .timeout(timeout)
  );

  sw_reset_dp #(
    .NUM_PORTS(NUM_PORTS), .PORT_BASE(PORT_BASE), .GLOBAL_DEV(GLOBAL_DEV),
    .TICKS_PER_MS(TICKS_PER_MS), .MAX_POLLS(MAX_POLLS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regRdata(regRdata),
    .status(dpStat), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata)
  );
endmodule

// File: rtl/sw_reset_seq_chk.sv
module sw_reset_seq_chk
  import sw_reset_pkg::*;
#(
  parameter int GLOBAL_DEV = 27
) (
  input logic              clk,
  input logic              rstN,
  input logic              regReq,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic [DATA_W-1:0] regWdata,
  input logic              regAck,
  input logic [DATA_W-1:0] regRdata,
  input logic              done,
  input logic              timeout
);
  logic isGlobal;
  assign isGlobal = (regAddr[ADDR_W-1:OFF_W] == DEV_W'(GLOBAL_DEV));

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    regReq && !regAck |=> regReq && $stable(regAddr) && $stable(regWe) && $stable(regWdata));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeout));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r10_timeout_single: assert property (@(posedge clk) disable iff (!rstN)
    timeout |=> !timeout);

  a_r10_idle_on_end: assert property (@(posedge clk) disable iff (!rstN)
    (done || timeout) |-> !regReq);

  a_r8_done_after_match: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(regAck && !regWe && ((regRdata & DONE_MASK) == DONE_MASK)));

  a_r9_timeout_after_miss: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeout) |-> $past(regAck && !regWe && ((regRdata & DONE_MASK) != DONE_MASK)));

  a_r6_reset_cmd: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && isGlobal |-> regWdata == RESET_CMD && regAddr[OFF_W-1:0] == OFF_GLB_CTRL);

  a_r3_port_disabled: assert property (@(posedge clk) disable iff (!rstN)
    regReq && regWe && !isGlobal |-> regWdata[1:0] == 2'b00);
endmodule

bind sw_reset_seq sw_reset_seq_chk #(.GLOBAL_DEV(GLOBAL_DEV)) u_chk (
  .clk(clk), .rstN(rstN), .regReq(regReq), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .regAck(regAck), .regRdata(regRdata),
  .done(done), .timeout(timeout)
);

// File: tb/sw_reset_seq_tb.sv
module sw_reset_seq_tb;
  import sw_reset_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NPORTS     = 8;
  localparam int PBASE      = 16;
  localparam int GDEV       = 27;
  localparam int TICKS      = 3;
  localparam int MAXP       = 4;
  localparam int DRAIN      = 2 * TICKS;
  localparam int LOGN       = 64;

  typedef struct packed {
    logic [3:0]  lat;
    logic [7:0]  failPolls;
    logic [15:0] goodStat;
    logic [15:0] badStat;
    logic [15:0] seed;
  } scen_t;

  localparam int NSCEN = 6;
  localparam scen_t SCEN [NSCEN] = '{
    '{4'd0, 8'd0, 16'hC800, 16'h0000, 16'hFFFF},
    '{4'd2, 8'd2, 16'hFFFF, 16'hC000, 16'h1234},
    '{4'd1, 8'd3, 16'hC800, 16'h4800, 16'h0003},
    '{4'd0, 8'd4, 16'hC800, 16'h8800, 16'hBEEF},
    '{4'd3, 8'd9, 16'hC800, 16'h0000, 16'h0000},
    '{4'd0, 8'd1, 16'hCBFF, 16'hC7FF, 16'h5A5A}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic regAck = 1'b0;
  logic [15:0] regRdata = '0;
  logic regReq, regWe, done, timeout;
  logic [9:0] regAddr;
  logic [15:0] regWdata;

  sw_reset_seq #(
    .NUM_PORTS(NPORTS), .PORT_BASE(PBASE), .GLOBAL_DEV(GDEV),
    .TICKS_PER_MS(TICKS), .MAX_POLLS(MAXP)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .regReq(regReq), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regAck(regAck),
    .regRdata(regRdata), .done(done), .timeout(timeout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nChecks = 0;
  int nFail = 0;
  scen_t curScen = '0;
  int cycle = 0;
  int waitCnt = 0;
  int reqStart = 0;
  int prevAck = 0;
  bit havePrev = 0;
  int statReads = 0;
  int nLog = 0;
  int doneCnt = 0;
  int toCnt = 0;
  logic [9:0]  logAddr [LOGN];
  logic        logWe   [LOGN];
  logic [15:0] logData [LOGN];
  int          logGap  [LOGN];

  function automatic logic [15:0] portVal(logic [15:0] seed, int idx);
    return seed ^ (16'(idx) * 16'h2461);
  endfunction

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // register slave model, driven at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cycle++;
      regAck = 1'b0;
      if (regReq) begin
        if (waitCnt == 0) reqStart = cycle;
        if (waitCnt >= int'(curScen.lat)) begin
          logic [15:0] rv;
          int k;
          rv = '0;
          if (!regWe) begin
            if (int'(regAddr[9:5]) == GDEV) begin
              k = statReads;
              statReads++;
              rv = (k >= int'(curScen.failPolls)) ? curScen.goodStat : curScen.badStat;
            end else begin
              rv = portVal(curScen.seed, int'(regAddr[9:5]) - PBASE);
            end
          end
          if (nLog < LOGN) begin
            logAddr[nLog] = regAddr;
            logWe[nLog]   = regWe;
            logData[nLog] = regWe ? regWdata : rv;
            logGap[nLog]  = havePrev ? (reqStart - prevAck) : -1;
          end
          nLog++;
          prevAck  = cycle;
          havePrev = 1'b1;
          regAck   = 1'b1;
          regRdata = rv;
          waitCnt  = 0;
        end else begin
          waitCnt++;
        end
      end else begin
        waitCnt = 0;
      end
      if (done)    doneCnt++;
      if (timeout) toCnt++;
    end
  end

  task automatic runScen(int idx, bit injectStart);
    int expReads, bad;
    bit expDone;
    @(negedge clk);
    curScen   = SCEN[idx];
    nLog      = 0;
    havePrev  = 1'b0;
    statReads = 0;
    doneCnt   = 0;
    toCnt     = 0;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      if (injectStart && c == 20) start = 1'b1;
      if (injectStart && c == 21) start = 1'b0;
      if (doneCnt + toCnt > 0) break;
    end
    repeat (12) @(negedge clk);

    expDone  = int'(curScen.failPolls) < MAXP;
    expReads = expDone ? int'(curScen.failPolls) + 1 : MAXP;

    chk($sformatf("R8 done count scen %0d", idx), doneCnt, expDone ? 1 : 0);
    chk($sformatf("R9 timeout count scen %0d", idx), toCnt, expDone ? 0 : 1);
    chk($sformatf("R10 single completion scen %0d", idx), doneCnt + toCnt, 1);
    chk($sformatf("R10 idle after end scen %0d", idx), int'(regReq), 0);
    chk($sformatf("R9 R11 access count scen %0d", idx), nLog, 2*NPORTS + 1 + expReads);
    if (nLog == 2*NPORTS + 1 + expReads) begin
      bad = 0;
      for (int i = 0; i < NPORTS; i++) begin
        if (logAddr[2*i]   != {5'(PBASE + i), 5'd4} || logWe[2*i])     bad++;
        if (logAddr[2*i+1] != {5'(PBASE + i), 5'd4} || !logWe[2*i+1]) bad++;
        if (i > 0 && logGap[2*i] != 1) bad++;
        if (logGap[2*i+1] != 1) bad++;
      end
      chk($sformatf("R2 port sweep order scen %0d", idx), bad, 0);
      bad = 0;
      for (int i = 0; i < NPORTS; i++)
        if (logData[2*i+1] != (portVal(curScen.seed, i) & 16'hFFFC)) bad++;
      chk($sformatf("R3 port write value scen %0d", idx), bad, 0);
      chk($sformatf("R6 reset write addr scen %0d", idx),
          int'(logAddr[2*NPORTS]), int'({5'(GDEV), 5'd4}));
      chk($sformatf("R6 reset write data scen %0d", idx),
          int'(logData[2*NPORTS]), 32'hC400);
      chk($sformatf("R6 reset write is write scen %0d", idx), int'(logWe[2*NPORTS]), 1);
      chk($sformatf("R5 drain gap scen %0d", idx), logGap[2*NPORTS], DRAIN + 1);
      bad = 0;
      for (int j = 0; j < expReads; j++) begin
        int a;
        a = 2*NPORTS + 1 + j;
        if (logAddr[a] != {5'(GDEV), 5'd0} || logWe[a]) bad++;
        if (logGap[a] != ((j == 0) ? 1 : TICKS + 1)) bad++;
      end
      chk($sformatf("R7 status poll addr and spacing scen %0d", idx), bad, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 req low in reset", int'(regReq), 0);
    chk("R1 done low in reset", int'(done), 0);
    chk("R1 timeout low in reset", int'(timeout), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 no access while idle", nLog, 0);
    chk("R1 outputs quiet while idle", int'(regReq) + int'(done) + int'(timeout), 0);

    for (int s = 0; s < NSCEN; s++) runScen(s, 1'b0);

    // stray start during the port sweep must be ignored
    runScen(1, 1'b1);
    chk("R11 no restart after stray start", doneCnt, 1);

    // R4: with latency the request is held; checked via counts and assertion
    runScen(4, 1'b1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule